// File: doc/BRIEF.md
# Partial-Store Edge Mask Generator

This block turns a pair of byte addresses into the write-enable mask for one aligned 8-byte chunk of a span. The start address selects the chunk and the first element that is kept; the end address can cut the mask short when it falls in the same 8-byte chunk. Elements may be 8, 16 or 32 bits wide, so the mask is 8, 4 or 2 bits wide. Element order within the chunk is either big-endian or little-endian.

The caller raises a one-cycle strobe with the operands. One clock later the block returns the mask, zero-extended to 64 bits, and a strobe marking it as valid. It can also report a subtract-style overflow when the start address lies above the end address. The flag lands in a 32-bit or a 64-bit condition slot, chosen by the addressing mode, and only when condition reporting is enabled.

Top module: `edge_mask_unit`

## Requirements
- R1: While reset is asserted and after its release, before any strobe, `res_valid`, `res_mask`, `ovf_narrow` and `ovf_wide` are all zero.
- R2: A result appears on the outputs in the clock cycle after `op_valid` is sampled high, with `res_valid` high for exactly that cycle. When `op_valid` is low, `res_mask` and both flags keep their previous values.
- R3: With `elem_size`=00 (bytes) and `little_end`=0, byte `k` of the chunk (address bits [2:0]=k) maps to mask bit 7-k. Every byte at or after the start byte is enabled.
- R4: With `elem_size`=00 and `little_end`=1, byte `k` maps to mask bit k. Every byte at or after the start byte is enabled.
- R5: With `elem_size`=01, the element index is address bits [2:1] and the mask is 4 bits wide. Index i maps to bit 3-i when `little_end`=0 and to bit i when `little_end`=1.
- R6: With `elem_size`=10 or 11, the element index is address bit 2 and the mask is 2 bits wide. Index i maps to bit 1-i when `little_end`=0 and to bit i when `little_end`=1.
- R7: Two addresses are in the same chunk when bits [31:3] match (`addr32`=1) or when bits [63:3] match (`addr32`=0). In that case, elements whose index is above the end address's element index are also cleared.
- R8: When `cc_en`=1 and the start address, taken as an unsigned 64-bit value, is greater than the end address, one overflow flag is set: `ovf_narrow` if `addr32`=1, otherwise `ovf_wide`. The other flag is 0, and both are 0 when start is not greater than end.
- R9: When `cc_en`=0, both overflow flags are 0 in the result, whatever the addresses.
- R10: Bits of `res_mask` above the element mask width are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operand strobe |
| start_addr | input | 64 | First byte address of the span |
| end_addr | input | 64 | Last byte address of the span |
| elem_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| little_end | input | 1 | 1 selects little-endian element order |
| addr32 | input | 1 | 1 selects 32-bit addressing |
| cc_en | input | 1 | 1 enables overflow reporting |
| res_valid | output | 1 | Result strobe |
| res_mask | output | 64 | Zero-extended edge mask |
| ovf_narrow | output | 1 | 32-bit condition overflow |
| ovf_wide | output | 1 | 64-bit condition overflow |

## Verification
The bench sweeps every pair of low address bits against every element size, both orders and both addressing modes. The pairs are placed in four chunk arrangements: the same chunk, neighbouring chunks, chunks that differ only above bit 31, and a start that lies above the end. An end-trimming comparison that uses the wrong address bits would show up where the chunks differ only above bit 31: the narrow mode would fail to trim, or the wide mode would trim when it should not. A mirrored or off-by-one shift corrupts the edge bits at start index 0 or at the last index. An overflow routed to the wrong slot, or raised with `cc_en` low, is caught in the start-above-end arrangement.

// File: rtl/edge_mask_unit.sv
`timescale 1ns/1ps
module edge_mask_unit #(
  parameter int ADDR_W = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [1:0]        elem_size,
  input  logic              little_end,
  input  logic              addr32,
  input  logic              cc_en,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_mask,
  output logic              ovf_narrow,
  output logic              ovf_wide
);
  localparam int BLK_LSB = 3;

  wire [2:0] s8 = start_addr[2:0];
  wire [2:0] e8 = end_addr[2:0];
  wire [1:0] s16 = start_addr[2:1];
  wire [1:0] e16 = end_addr[2:1];
  wire       s32 = start_addr[2];
  wire       e32 = end_addr[2];

  wire same_narrow = start_addr[NARROW_W-1:BLK_LSB] == end_addr[NARROW_W-1:BLK_LSB];
  wire same_wide   = start_addr[ADDR_W-1:BLK_LSB] == end_addr[ADDR_W-1:BLK_LSB];
  wire same_blk    = addr32 ? same_narrow : same_wide;

  wire [7:0] b_st = little_end ? 8'(8'hFF << s8) : 8'(8'hFF >> s8);
  wire [7:0] b_en = little_end ? 8'(8'hFF >> (3'd7 - e8)) : 8'(8'hFF << (3'd7 - e8));
  wire [3:0] h_st = little_end ? 4'(4'hF << s16) : 4'(4'hF >> s16);
  wire [3:0] h_en = little_end ? 4'(4'hF >> (2'd3 - e16)) : 4'(4'hF << (2'd3 - e16));
  wire [1:0] w_st = little_end ? 2'(2'h3 << s32) : 2'(2'h3 >> s32);
  wire [1:0] w_en = little_end ? 2'(2'h3 >> (1'b1 - e32)) : 2'(2'h3 << (1'b1 - e32));

  logic [7:0] edge_m;
  always_comb begin
    case (elem_size)
      2'b00:   edge_m = same_blk ? (b_st & b_en) : b_st;
      2'b01:   edge_m = {4'b0, same_blk ? (h_st & h_en) : h_st};
      default: edge_m = {6'b0, same_blk ? (w_st & w_en) : w_st};
    endcase
  end

  wire start_above = start_addr > end_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_mask   <= '0;
      ovf_narrow <= 1'b0;
      ovf_wide   <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_mask   <= {{(ADDR_W-8){1'b0}}, edge_m};
        ovf_narrow <= cc_en & start_above & addr32;
        ovf_wide   <= cc_en & start_above & ~addr32;
      end
    end
  end
endmodule

module edge_mask_unit_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [1:0]        elem_size,
  input logic              cc_en,
  input logic              res_valid,
  input logic [ADDR_W-1:0] res_mask,
  input logic              ovf_narrow,
  input logic              ovf_wide
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res_mask) && $stable(ovf_narrow) && $stable(ovf_wide));
  a_r8_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_narrow && ovf_wide));
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !cc_en) |=> !ovf_narrow && !ovf_wide);
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_mask[ADDR_W-1:8] == '0);
  a_r6_word_width: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && elem_size[1]) |=> res_mask[ADDR_W-1:2] == '0);
  a_r5_half_width: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && elem_size == 2'b01) |=> res_mask[ADDR_W-1:4] == '0);
endmodule

bind edge_mask_unit edge_mask_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .elem_size(elem_size),
  .cc_en(cc_en), .res_valid(res_valid), .res_mask(res_mask),
  .ovf_narrow(ovf_narrow), .ovf_wide(ovf_wide)
);

// File: tb/sim_edge_mask_unit.sv
`timescale 1ns/1ps
module sim_edge_mask_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [63:0] start_addr = '0, end_addr = '0;
  logic [1:0] elem_size = '0;
  logic little_end = 1'b0, addr32 = 1'b0, cc_en = 1'b0;
  logic res_valid;
  logic [63:0] res_mask;
  logic ovf_narrow, ovf_wide;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  edge_mask_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
    .start_addr(start_addr), .end_addr(end_addr), .elem_size(elem_size),
    .little_end(little_end), .addr32(addr32), .cc_en(cc_en),
    .res_valid(res_valid), .res_mask(res_mask),
    .ovf_narrow(ovf_narrow), .ovf_wide(ovf_wide)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [2:0] s, input logic [2:0] e,
                                       input logic [1:0] sz, input logic le, input logic same);
    logic [7:0] m = '0;
    int sh = (sz == 2'b00) ? 0 : (sz == 2'b01) ? 1 : 2;
    int n = 8 >> sh;
    int si = int'(s) >> sh;
    int ei = int'(e) >> sh;
    for (int i = 0; i < n; i++)
      if (i >= si && (!same || i <= ei)) m[le ? i : n - 1 - i] = 1'b1;
    return m;
  endfunction

  function automatic string tag_for(input logic [1:0] sz, input logic le, input logic same);
    string t;
    if (sz == 2'b00) t = le ? "R4" : "R3";
    else if (sz == 2'b01) t = "R5";
    else t = "R6";
    if (same) t = {t, "/R7"};
    return t;
  endfunction

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] base = 64'h1234_5678_9ABC_DE00;
    repeat (3) @(negedge clk);
    check("R1 valid", {63'b0, res_valid}, 64'd0);
    check("R1 mask", res_mask, 64'd0);
    check("R1 flags", {62'b0, ovf_narrow, ovf_wide}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {61'b0, res_valid, ovf_narrow, ovf_wide}, 64'd0);
    check("R1 mask after release", res_mask, 64'd0);

    for (int p = 0; p < 4; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int le = 0; le < 2; le++)
          for (int a32 = 0; a32 < 2; a32++)
            for (int lo = 0; lo < 64; lo++) begin
              logic [63:0] sa, ea;
              logic same, above, cc;
              logic [7:0] exp_m;
              logic [63:0] prev;
              sa = base | 64'(lo[2:0]);
              ea = base | 64'(lo[5:3]);
              if (p == 1) ea = ea + 64'd8;
              if (p == 2) ea = ea ^ (64'd1 << 40);
              if (p == 3) sa = sa + 64'd8;
              cc = lo[0] ^ lo[3] ^ le[0];
              same = a32 ? (sa[31:3] == ea[31:3]) : (sa[63:3] == ea[63:3]);
              above = sa > ea;
              exp_m = model(sa[2:0], ea[2:0], 2'(sz), le[0], same);
              start_addr = sa; end_addr = ea; elem_size = 2'(sz);
              little_end = le[0]; addr32 = a32[0]; cc_en = cc;
              op_valid = 1'b1;
              @(negedge clk);
              op_valid = 1'b0;
              check("R2 valid", {63'b0, res_valid}, 64'd1);
              check(tag_for(2'(sz), le[0], same), res_mask, {56'b0, exp_m});
              check(cc ? "R8 flags" : "R9 flags", {62'b0, ovf_narrow, ovf_wide},
                    {62'b0, cc & above & a32[0], cc & above & ~a32[0]});
              check("R10 upper", {8'b0, res_mask[63:8]}, 64'd0);
              if (lo == 9) begin
                prev = res_mask;
                start_addr = ~sa; end_addr = 64'd0; cc_en = 1'b1; elem_size = 2'b00;
                @(negedge clk);
                check("R2 drop", {63'b0, res_valid}, 64'd0);
                check("R2 hold mask", res_mask, prev);
                check("R2 hold flags", {62'b0, ovf_narrow, ovf_wide},
                      {62'b0, cc & above & a32[0], cc & above & ~a32[0]});
              end
            end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule